// File: doc/BRIEF.md
# Wait-Stated Byte ROM Read Controller

This block lets an on-chip master read single bytes from an external byte-wide ROM on a parallel bus. The master gives a 16-bit address with a one-cycle request pulse. The block then runs one read cycle through a fixed series of bus states and returns the byte with a one-cycle acknowledge. Three extended-address lines come from a page register that the master writes separately. Together with the 16-bit address they reach 512 KB of ROM, where the 16-bit address alone reaches 64K x 8.

The sequencer steps through the states IDLE, T1, T2W1, T2W (three times), T2, T3 and T3H. The transitions are as follows:
- IDLE goes to T1 when a request starts.
- T1 goes to T2W1, and T2W1 goes to the first T2W.
- T2W repeats until a wait counter reaches its last count, then goes to T2.
- T2 goes to T3, and T3 goes to T3H.
- T3H goes to T1 if a request is held or arriving, and to IDLE otherwise.

One request can be held while a cycle is in progress. It starts without a gap after the current T3H. The block never drives the data bus.

Top module: `rom_rd_ctrl`

## Requirements
- R1: During and right after reset, `rom_cs_n` is 1, `rd_ack` is 0 and `rom_addr`/`rom_ext` are 0. While idle, `rom_addr` and `rom_ext` stay 0.
- R2: A `rd_req` pulse seen in IDLE puts the bus in T1 in the next cycle. In T1, `rom_addr` equals the requested address and `rom_cs_n` is still 1.
- R3: `rom_cs_n` is 0 for exactly five consecutive cycles (T2W1, three T2W, T2), starting the cycle after T1.
- R4: The byte returned is the value on `rom_dq_i` in the last cycle with `rom_cs_n` low (T2).
- R5: `rom_cs_n` is 1 in T3 and in the following T3H. `rom_addr` and `rom_ext` hold their values across all eight cycles from T1 to T3H.
- R6: `rd_ack` is 1 for exactly one cycle, the cycle after T3H, and `rd_data` carries the byte in that cycle.
- R7: `rom_ext` equals the page register value at entry to T1. A `page_wr` during a cycle changes only later cycles. The ROM byte address is {`rom_ext`, `rom_addr`}, 19 bits.
- R8: A request arriving while a cycle is in progress is held. Its T1 is the cycle right after the current T3H, and that cycle is also the acknowledge cycle of the earlier read.
- R9: `rom_dq_oe` is 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | One-cycle read request |
| rd_addr | input | 16 | Byte address within the page, valid with `rd_req` |
| page_wr | input | 1 | Page register write strobe |
| page_din | input | 3 | New page register value |
| rd_ack | output | 1 | One-cycle read completion |
| rd_data | output | 8 | Byte read, valid with `rd_ack` |
| rom_addr | output | 16 | ROM address bus |
| rom_ext | output | 3 | Extended address lines |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| rom_dq_i | input | 8 | ROM data bus, input side |
| rom_dq_o | output | 8 | ROM data bus, output side (unused, zero) |
| rom_dq_oe | output | 1 | ROM data bus drive enable, held 0 |

## Verification
The hardest case to reach is a read whose page register is rewritten mid-cycle while a second request is also queued. The second read must start in the ack cycle of the first and must use the new page, while the first returns data from the old page. The bench reaches this case by injecting, at chosen wait-state cycles, a page write and then a request. It then checks both reads state by state. A sweep over all eight pages and many addresses, with a ROM model whose data depends on the full 19-bit address, covers ordinary reads.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2W1 = 3'd2,
        ST_T2W  = 3'd3,
        ST_T2   = 3'd4,
        ST_T3   = 3'd5,
        ST_T3H  = 3'd6
    } rd_state_e;

endpackage

// File: rtl/rom_page_reg.sv
module rom_page_reg #(
    parameter int EXT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             page_wr,
    input  logic [EXT_W-1:0] page_din,
    output logic [EXT_W-1:0] page_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (page_wr) begin
            page_q <= page_din;
        end
    end

endmodule

// File: rtl/rom_req_hold.sv
module rom_req_hold #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              seq_idle,
    input  logic              seq_last,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);

    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;

    // A cycle may begin from idle, or back to back after the hold state.
    always_comb begin
        start      = (seq_idle && req) || (seq_last && (pend_q || req));
        start_addr = pend_q ? pend_addr_q : req_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (seq_last && pend_q) begin
            // held request leaves now; a fresh request takes its slot
            pend_q      <= req;
            pend_addr_q <= req_addr;
        end else if (!seq_idle && !seq_last && req && !pend_q) begin
            pend_q      <= 1'b1;
            pend_addr_q <= req_addr;
        end
    end

    // R8: a held request only exists while a cycle is running
    a_r8_held_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !seq_idle);

    // R8: a held request is consumed at the end of the running cycle
    a_r8_held_starts_after_t3h: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && seq_last) |-> start);

endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int EXT_W   = 3,
    parameter int DATA_W  = 8,
    parameter int NUM_T2W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [EXT_W-1:0]  page_q,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [EXT_W-1:0]  bus_ext,
    output logic              bus_cs_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ack,
    output logic              seq_idle,
    output logic              seq_last
);

    localparam int CNT_W = (NUM_T2W > 1) ? $clog2(NUM_T2W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_T2W - 1);

    rd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [EXT_W-1:0]  ext_q;
    logic [DATA_W-1:0] data_q;
    logic              cs_n_q;
    logic              ack_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_T1;
            ST_T1:   state_d = ST_T2W1;
            ST_T2W1: state_d = ST_T2W;
            ST_T2W:  if (wcnt_q == LAST_CNT) state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = ST_T3H;
            ST_T3H:  state_d = start ? ST_T1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            cs_n_q <= 1'b1;
            ack_q  <= 1'b0;
            data_q <= '0;
            addr_q <= '0;
            ext_q  <= '0;
        end else begin
            wcnt_q <= (state_q == ST_T2W && state_d == ST_T2W) ? wcnt_q + 1'b1 : '0;
            cs_n_q <= !(state_d == ST_T2W1 || state_d == ST_T2W || state_d == ST_T2);
            ack_q  <= (state_q == ST_T3H);
            if (state_q == ST_T2) begin
                data_q <= bus_din;
            end
            if (start) begin
                addr_q <= start_addr;
                ext_q  <= page_q;
            end
        end
    end

    always_comb begin
        bus_addr = (state_q != ST_IDLE) ? addr_q : '0;
        bus_ext  = (state_q != ST_IDLE) ? ext_q  : '0;
        bus_cs_n = cs_n_q;
        rd_ack   = ack_q;
        rd_data  = data_q;
        seq_idle = (state_q == ST_IDLE);
        seq_last = (state_q == ST_T3H);
    end

    // R3: chip select goes low only right after T1
    a_r3_cs_fall_after_t1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> $past(state_q) == ST_T1);

    // R3: wait counter never passes its last value
    a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= LAST_CNT);

    // R4: returned byte is the bus value from the T2 cycle
    a_r4_data_from_t2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> rd_data == $past(bus_din, 3));

    // R5: chip select is released through T3 and T3H
    a_r5_cs_high_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T3 || state_q == ST_T3H) |-> cs_n_q);

    // R6: acknowledge is a single-cycle pulse following T3H
    a_r6_ack_after_t3h: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> ($past(state_q) == ST_T3H) && $past(!ack_q));

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int EXT_W   = 3,
    parameter int DATA_W  = 8,
    parameter int NUM_T2W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              page_wr,
    input  logic [EXT_W-1:0]  page_din,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [EXT_W-1:0]  rom_ext,
    output logic              rom_cs_n,
    input  logic [DATA_W-1:0] rom_dq_i,
    output logic [DATA_W-1:0] rom_dq_o,
    output logic              rom_dq_oe
);

    logic [EXT_W-1:0]  page_q;
    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic              seq_idle;
    logic              seq_last;

    rom_page_reg #(.EXT_W(EXT_W)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .page_wr  (page_wr),
        .page_din (page_din),
        .page_q   (page_q)
    );

    rom_req_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (rd_req),
        .req_addr   (rd_addr),
        .seq_idle   (seq_idle),
        .seq_last   (seq_last),
        .start      (start),
        .start_addr (start_addr)
    );

    rom_rd_seq #(
        .ADDR_W  (ADDR_W),
        .EXT_W   (EXT_W),
        .DATA_W  (DATA_W),
        .NUM_T2W (NUM_T2W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .page_q     (page_q),
        .bus_din    (rom_dq_i),
        .bus_addr   (rom_addr),
        .bus_ext    (rom_ext),
        .bus_cs_n   (rom_cs_n),
        .rd_data    (rd_data),
        .rd_ack     (rd_ack),
        .seq_idle   (seq_idle),
        .seq_last   (seq_last)
    );

    // R9: read-only controller, the data bus is never driven
    assign rom_dq_o  = '0;
    assign rom_dq_oe = 1'b0;

    // R5: address and page lines hold from T1 through T3H
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && $past(!seq_idle) && !$past(seq_last)) |-> ($stable(rom_addr) && $stable(rom_ext)));

    // R1: idle bus shows no address and no select
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (rom_cs_n && rom_addr == '0 && rom_ext == '0));

endmodule

// File: tb/sim_rom_rd_ctrl.sv
module sim_rom_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        page_wr = 1'b0;
    logic [2:0]  page_din = '0;
    logic        rd_ack;
    logic [7:0]  rd_data;
    logic [15:0] rom_addr;
    logic [2:0]  rom_ext;
    logic        rom_cs_n;
    logic [7:0]  rom_dq_i;
    logic [7:0]  rom_dq_o;
    logic        rom_dq_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rom_rd_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .page_wr   (page_wr),
        .page_din  (page_din),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rom_addr  (rom_addr),
        .rom_ext   (rom_ext),
        .rom_cs_n  (rom_cs_n),
        .rom_dq_i  (rom_dq_i),
        .rom_dq_o  (rom_dq_o),
        .rom_dq_oe (rom_dq_oe)
    );

    // ROM model: byte depends on all 19 address bits, only driven while selected
    function automatic logic [7:0] rom_byte(input logic [2:0] pg, input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ {pg, 5'b10101};
    endfunction

    assign rom_dq_i = rom_cs_n ? 8'h00 : rom_byte(rom_ext, rom_addr);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at the negedge inside T1 of a read of address a on page pg.
    task automatic body(input logic [15:0] a, input logic [2:0] pg,
                        input bit mid_pg_en, input logic [2:0] mid_pg,
                        input bit hold_en, input logic [15:0] hold_a);
        chk(rom_cs_n == 1'b1, "R2 cs high in T1", rom_cs_n, 1);
        chk(rom_addr == a, "R2 address in T1", rom_addr, a);
        chk(rom_ext == pg, "R7 page in T1", rom_ext, pg);
        chk(rom_dq_oe == 1'b0, "R9 no drive in T1", rom_dq_oe, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            page_wr = 1'b0;
            rd_req  = 1'b0;
            if (mid_pg_en && i == 1) begin
                page_wr  = 1'b1;
                page_din = mid_pg;
            end
            if (hold_en && i == 2) begin
                rd_req  = 1'b1;
                rd_addr = hold_a;
            end
            chk(rom_cs_n == 1'b0, "R3 cs low in wait/T2", rom_cs_n, 0);
            chk(rom_addr == a && rom_ext == pg, "R5 address held while selected", {rom_ext, rom_addr}, {pg, a});
            chk(rd_ack == 1'b0, "R6 no early ack", rd_ack, 0);
            chk(rom_dq_oe == 1'b0, "R9 no drive while selected", rom_dq_oe, 0);
        end
        @(negedge clk);
        page_wr = 1'b0;
        rd_req  = 1'b0;
        chk(rom_cs_n == 1'b1, "R5 cs high in T3", rom_cs_n, 1);
        chk(rom_addr == a && rom_ext == pg, "R5 address held in T3", {rom_ext, rom_addr}, {pg, a});
        @(negedge clk);
        chk(rom_cs_n == 1'b1, "R5 cs high in T3H", rom_cs_n, 1);
        chk(rom_addr == a && rom_ext == pg, "R5 address held in T3H", {rom_ext, rom_addr}, {pg, a});
        chk(rd_ack == 1'b0, "R6 no ack in T3H", rd_ack, 0);
        @(negedge clk);
        chk(rd_ack == 1'b1, "R6 ack after T3H", rd_ack, 1);
        chk(rd_data == rom_byte(pg, a), "R4 data from T2", rd_data, rom_byte(pg, a));
        if (hold_en) begin
            chk(rom_addr == hold_a && rom_cs_n == 1'b1, "R8 held request in T1 at ack cycle", rom_addr, hold_a);
        end else begin
            @(negedge clk);
            chk(rd_ack == 1'b0, "R6 ack lasts one cycle", rd_ack, 0);
            chk(rom_cs_n == 1'b1 && rom_addr == 16'h0 && rom_ext == 3'h0, "R1 idle bus quiet", rom_addr, 0);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input logic [2:0] pg);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_req  = 1'b0;
        body(a, pg, 1'b0, 3'h0, 1'b0, 16'h0);
    endtask

    task automatic set_page(input logic [2:0] pg);
        @(negedge clk);
        page_wr  = 1'b1;
        page_din = pg;
        @(negedge clk);
        page_wr  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rom_cs_n == 1'b1, "R1 cs high in reset", rom_cs_n, 1);
        chk(rd_ack == 1'b0, "R1 ack low in reset", rd_ack, 0);
        chk(rom_addr == 16'h0 && rom_ext == 3'h0, "R1 address zero in reset", rom_addr, 0);
        chk(rom_dq_oe == 1'b0, "R9 no drive in reset", rom_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rom_cs_n == 1'b1 && rd_ack == 1'b0, "R1 idle after reset", rom_cs_n, 1);

        // sweep all pages over a spread of addresses
        for (int pg = 0; pg < 8; pg++) begin
            set_page(3'(pg));
            for (int k = 0; k < 32; k++) begin
                do_read(16'(k * 2053 + pg * 97 + (k == 31 ? 16'hFFFF : 16'h0)), 3'(pg));
            end
        end

        // R7 + R8: page rewritten mid-cycle, second request held
        set_page(3'd2);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = 16'h1234;
        @(negedge clk);
        rd_req  = 1'b0;
        body(16'h1234, 3'd2, 1'b1, 3'd5, 1'b1, 16'hBEEF);
        body(16'hBEEF, 3'd5, 1'b0, 3'h0, 1'b0, 16'h0);

        // R7: later read uses the new page
        do_read(16'h00FF, 3'd5);

        // R2: request issued back to back from idle right after a read
        do_read(16'hFFFF, 3'd5);
        do_read(16'h0000, 3'd5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule